// File: doc/BRIEF.md
# Delay-Slot Fetch Address Sequencer

This block owns the fetch address of a small 32-bit pipelined core whose control transfers take effect one instruction late. On each cycle it looks at the instruction word fetched from the current address. It takes a taken/not-taken verdict from the execute logic and a stall input, and it chooses the address to fetch on the next cycle.

When it sees a conditional branch that is taken, or a direct jump, it computes the destination and parks it in a one-entry redirect register. It then fetches the following word, the delay slot, exactly once. On the next unstalled cycle it loads the parked destination. Branch destinations are relative to the slot address and counted in words. Jump destinations keep the top four bits of the slot address and splice in a 26-bit word index. A stall freezes the address and the parked redirect together.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset sets `fetchAddr` to the parameter `RESET_VECTOR` and discards any parked redirect, so the first unstalled cycle after reset advances to `RESET_VECTOR + 4`.
- R2: On an unstalled cycle with no parked redirect and no control transfer, `fetchAddr` increases by 4.
- R3: The opcode is `instr[31:26]`. Opcodes 6'b000100 and 6'b000101 are conditional branches and redirect only when `branchTaken` is 1. Every other opcode that is not a jump, including 6'b000000, is sequential, and for these `branchTaken` has no effect.
- R4: A taken branch at address A targets A + 4 + ({{14{instr[15]}}, instr[15:0], 2'b00}).
- R5: A branch with a negative offset (instr[15] = 1) produces a target below the branch address.
- R6: Opcodes 6'b000010 and 6'b000011 always redirect to {(A+4)[31:28], instr[25:0], 2'b00}. The 26-bit field is not extended and not added.
- R7: After a redirecting instruction at A, the next issued address is A + 4, issued exactly once, and the address issued after it is the target.
- R8: While `stall` is 1, `fetchAddr` and any parked redirect are held unchanged, including when the stall falls on the delay slot.
- R9: A branch or jump that sits in a delay slot is treated as sequential: the parked redirect is taken and the slot's own transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze address and redirect state |
| instr | input | 32 | Instruction word fetched from `fetchAddr` |
| branchTaken | input | 1 | Condition result for a branch in `instr` |
| fetchAddr | output | 32 | Current fetch address |

## Verification
The bench targets the ways a late redirect can go wrong. If the slot is skipped, the target shows up right after the branch. If the slot is issued twice, the redirect is lost or delayed. If the offset is measured from the branch instead of the slot, every branch lands 4 bytes early. If the offset is extended without its sign, backward branches land far above the branch. A stall during the slot must not consume the parked target, or the redirect is lost. A jump whose field is sign-extended or added to the address lands in the wrong region. Randomized mixes of branches, jumps, stalls and transfers placed in slots are compared against a bench reference model.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W = 32;
  localparam int OPC_W  = 6;
  localparam int OFF_W  = 16;
  localparam int IDX_W  = 26;
  localparam int REGION_W = ADDR_W - IDX_W - 2;
  localparam int SEXT_W = ADDR_W - OFF_W - 2;

  localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_J   = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_JAL = 6'b000011;

  typedef struct packed {
    logic advance;   // step sequentially by one word
    logic redirect;  // load parked target
    logic capture;   // park a new target
    logic selJump;   // parked target comes from jump path
  } ctrlStrobes_t;
endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                stall,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                branchTaken,
  input  logic                pendValid,
  output ctrlStrobes_t        strobes
);
  logic isBranch, isJump, transfer;

  always_comb begin
    isBranch = (opcode == OPC_BEQ) || (opcode == OPC_BNE);
    isJump   = (opcode == OPC_J)   || (opcode == OPC_JAL);
    transfer = isJump || (isBranch && branchTaken);
    strobes.redirect = !stall && pendValid;
    strobes.advance  = !stall && !pendValid;
    strobes.capture  = !stall && !pendValid && transfer;
    strobes.selJump  = isJump;
  end

  // R9: a slot never starts a second redirect
  slot_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.redirect, strobes.capture}));

  // R3: not-taken branches never park a target
  nottaken_chk: assert property (@(posedge clk) disable iff (rst)
    ((opcode == OPC_BEQ || opcode == OPC_BNE) && !branchTaken) |-> !strobes.capture);
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_VECTOR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   instr,
  output logic [ADDR_W-1:0]   pcQ,
  output logic                pendValid
);
  logic [ADDR_W-1:0] pendTarget;
  logic [ADDR_W-1:0] slotAddr, branchTgt, jumpTgt, newTgt;

  always_comb begin
    slotAddr  = pcQ + ADDR_W'(4);
    branchTgt = slotAddr + {{SEXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0], 2'b00};
    jumpTgt   = {slotAddr[ADDR_W-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};
    newTgt    = strobes.selJump ? jumpTgt : branchTgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ        <= RESET_VECTOR;
      pendValid  <= 1'b0;
      pendTarget <= '0;
    end else if (strobes.redirect) begin
      pcQ        <= pendTarget;
      pendValid  <= 1'b0;
    end else if (strobes.advance) begin
      pcQ        <= slotAddr;
      pendValid  <= strobes.capture;
      if (strobes.capture) pendTarget <= newTgt;
    end
  end

  // R7: a captured transfer is followed by the slot address
  slot_issue_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> (pcQ == $past(pcQ) + ADDR_W'(4)) && pendValid);

  // R7: redirect consumes the parked entry
  redirect_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.redirect |=> !pendValid);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && !strobes.capture) |=> (pcQ == $past(pcQ) + ADDR_W'(4)) && !pendValid);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import seq_pkg::*;
#(
  parameter logic [31:0] RESET_VECTOR = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic        branchTaken,
  output logic [31:0] fetchAddr
);
  ctrlStrobes_t strobes;
  logic         pendValid;

  seq_control u_ctrl (
    .clk(clk), .rst(rst), .stall(stall),
    .opcode(instr[ADDR_W-1 -: OPC_W]), .branchTaken(branchTaken),
    .pendValid(pendValid), .strobes(strobes)
  );

  seq_datapath #(.RESET_VECTOR(RESET_VECTOR)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .instr(instr),
    .pcQ(fetchAddr), .pendValid(pendValid)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(fetchAddr) && $stable(pendValid));

  // R1
  reset_vec_chk: assert property (@(posedge clk)
    rst |=> fetchAddr == RESET_VECTOR && !pendValid);
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam logic [31:0] RV = 32'h0000_1000;
  logic clk = 0, rst = 1, stall = 0, branchTaken = 0;
  logic [31:0] instr = 0;
  logic [31:0] fetchAddr;
  int nChecks = 0, nFails = 0;
  logic [31:0] mPc, mTgt;
  logic mPend;

  pc_sequencer #(.RESET_VECTOR(RV)) dut (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .branchTaken(branchTaken), .fetchAddr(fetchAddr));

  always #5 clk = ~clk;

  function automatic logic [31:0] brTarget(logic [31:0] a, logic [31:0] ins);
    return a + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
  endfunction
  function automatic logic [31:0] jTarget(logic [31:0] a, logic [31:0] ins);
    logic [31:0] s;
    s = a + 32'd4;
    return {s[31:28], ins[25:0], 2'b00};
  endfunction
  function automatic logic [31:0] mkBr(logic [5:0] op, logic [15:0] off);
    return {op, 10'h0, off};
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    nChecks++;
    if (fetchAddr !== exp) begin
      nFails++;
      $display("FAIL %s: fetchAddr=%h expected=%h", tag, fetchAddr, exp);
    end
  endtask

  // drive one cycle, update model, compare after the edge
  task automatic step(string tag, logic [31:0] ins, logic tk, logic st);
    logic [5:0] op;
    logic tr;
    instr = ins; branchTaken = tk; stall = st;
    op = ins[31:26];
    if (!st) begin
      if (mPend) begin mPc = mTgt; mPend = 0; end
      else begin
        tr = (op == 6'b000010 || op == 6'b000011) ||
             ((op == 6'b000100 || op == 6'b000101) && tk);
        if (tr) begin
          mTgt = (op[5:1] == 5'b00001) ? jTarget(mPc, ins) : brTarget(mPc, ins);
          mPend = 1;
        end
        mPc = mPc + 32'd4;
      end
    end
    @(posedge clk); #1;
    check(tag, mPc);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: fetchAddr=%h expected=progress", fetchAddr);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd1234));
    mPc = RV; mPend = 0; mTgt = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 reset vector", RV);
    step("R1 first step", 32'h0, 0, 0);
    // R2 / R3: R-type and random sequential words, branchTaken ignored
    step("R2 seq", 32'h0000_0020, 1, 0);
    step("R3 rtype taken ignored", 32'h0123_4567, 1, 0);
    // R3: not-taken branch
    step("R3 not-taken", mkBr(6'b000100, 16'h0010), 0, 0);
    step("R3 after not-taken", 32'h0, 0, 0);
    // R4/R7 forward branch
    a = fetchAddr;
    step("R7 slot after fwd", mkBr(6'b000101, 16'h0008), 1, 0);
    if (fetchAddr !== a + 4) begin nFails++; $display("FAIL R7 slot: %h exp %h", fetchAddr, a+4); end
    nChecks++;
    step("R4 fwd target", 32'h0, 0, 0);
    nChecks++;
    if (fetchAddr !== a + 4 + 32'd32) begin nFails++; $display("FAIL R4: %h exp %h", fetchAddr, a+36); end
    // R5 backward branch
    a = fetchAddr;
    step("R7 slot after back", mkBr(6'b000100, 16'hFFFC), 1, 0);
    step("R5 back target", 32'h0, 0, 0);
    nChecks++;
    if (!(fetchAddr < a) || fetchAddr !== a + 4 - 32'd16) begin
      nFails++; $display("FAIL R5: %h exp %h", fetchAddr, a - 12);
    end
    // R6 jump and jal
    step("R7 slot j", {6'b000010, 26'h2AB_CDEF}, 0, 0);
    step("R6 j target", 32'h0, 0, 0);
    step("R7 slot jal", {6'b000011, 26'h000_0040}, 1, 0);
    step("R6 jal target", 32'h0, 0, 0);
    // R8 stall on branch cycle and on slot
    step("R8 stall branch", mkBr(6'b000100, 16'h0004), 1, 1);
    step("R7 slot", mkBr(6'b000100, 16'h0004), 1, 0);
    step("R8 stall slot", 32'h0, 0, 1);
    step("R8 stall slot2", 32'h0, 0, 1);
    step("R8 target after stall", 32'h0, 0, 0);
    // R9 transfer in delay slot dropped
    step("R7 slot", {6'b000010, 26'h0000100}, 0, 0);
    step("R9 slot jump dropped", mkBr(6'b000101, 16'h0100), 1, 0);
    step("R9 seq after", 32'h0, 0, 0);
    // R1 reset mid-redirect
    step("R7 slot", {6'b000010, 26'h0000200}, 0, 0);
    rst = 1; @(posedge clk); #1; rst = 0;
    mPc = RV; mPend = 0;
    check("R1 reset clears", RV);
    @(negedge clk);
    step("R1 no stale redirect", 32'h0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      int k;
      k = $urandom_range(0, 7);
      w = $urandom;
      case (k)
        0: w[31:26] = 6'b000100;
        1: w[31:26] = 6'b000101;
        2: w[31:26] = 6'b000010;
        3: w[31:26] = 6'b000011;
        4: w[31:26] = 6'b000000;
        default: ;
      endcase
      step("R2-mix R4 R6 R7 R8 random", w, 1'($urandom_range(0,1)),
           ($urandom_range(0,4) == 0));
    end
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule